// File: doc/BRIEF.md
# Bank and Rank Rotating Request Sequencer

This block drives a DRAM traffic source with a deterministic visiting order. Requests come in series, and every packet of a series goes to the same bank and rank with the same read or write type. When a series ends, the block picks the next target. It walks through every bank in use, then through the command type, then through the ranks. The sequence then starts again from the first bank of the first rank.

The block does not form addresses. An address composer downstream takes the bank, the rank, the type and the series-start flag, inserts the column bits itself and increments them within a series. A packet is issued in each cycle where `req_valid` and `req_ready` are both high.

The read mix is configured as a percentage, and only three values are accepted: all writes (0), all reads (100) and an even split (50). In the split mode the rank visit lasts twice as long, so each bank sees one read series and one write series before the rank changes. Any other percentage raises a configuration error and freezes the sequencer.

Top module: `bank_rank_rotator`

## Requirements
- R1: `cfg_err` is high exactly when `cfg_rd_pct` is not 0, 50 or 100. While it is high, `req_valid` is low and no counter advances, so the sequence resumes where it stopped once the value is legal again.
- R2: A packet issues on a clock edge where `req_valid` and `req_ready` are both high, and nothing advances otherwise. `req_first` is high on the first packet of each series. A series contains exactly `cfg_pkts` packets, and a value of 0 behaves as 1.
- R3: The bank of a series is the series index modulo `cfg_banks`. Bank, rank and type stay constant for all packets of the series.
- R4: The rank of a series is (series index / S) modulo `cfg_ranks`. S is 2×`cfg_banks` when `cfg_rd_pct` is 50, and `cfg_banks` otherwise.
- R5: The series index counts up by one per series and returns to 0 after `cfg_ranks`×S series.
- R6: When `cfg_rd_pct` is 50, the type flips at a series start whose index is a multiple of `cfg_banks`, and is kept at any other series start. The type resets to write, so the first series is a read series. `req_is_read` = 1 means read.
- R7: When `cfg_rd_pct` is 0 every packet is a write (`req_is_read` = 0). When it is 100 every packet is a read (`req_is_read` = 1).
- R8: After reset, the first packet starts a series on bank 0 and rank 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_banks | input | BANK_W+1 | Number of banks in use (1..2^BANK_W) |
| cfg_ranks | input | RANK_W+1 | Number of ranks in use (1..2^RANK_W) |
| cfg_rd_pct | input | 7 | Read percentage: 0, 50 or 100 |
| cfg_pkts | input | PKT_W | Packets per series |
| req_ready | input | 1 | Consumer accepts the current packet |
| req_valid | output | 1 | A packet is offered |
| req_first | output | 1 | The offered packet starts a series |
| req_bank | output | BANK_W | Bank of the offered packet |
| req_rank | output | RANK_W | Rank of the offered packet |
| req_is_read | output | 1 | 1 = read, 0 = write |
| cfg_err | output | 1 | Illegal read percentage |

## Verification
With one packet per series, every issued packet is also a series start. If that packet completes the last bank, the bank wrap, the type flip and the rank step all happen on the same clock edge. The split-mode vectors with `cfg_pkts` of 1 produce exactly this case. There, every packet is compared with a bench model that works out bank, rank and type by division and modulo of the packet index. Any slip in the ordering of wrap, flip and rank step shows up as a wrong rank or type on the next packet.

// File: rtl/bank_rank_rotator.sv
module bank_rank_rotator #(
  parameter int BANK_W = 3,
  parameter int RANK_W = 2,
  parameter int PKT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W:0]   cfg_banks,
  input  logic [RANK_W:0]   cfg_ranks,
  input  logic [6:0]        cfg_rd_pct,
  input  logic [PKT_W-1:0]  cfg_pkts,
  input  logic              req_ready,
  output logic              req_valid,
  output logic              req_first,
  output logic [BANK_W-1:0] req_bank,
  output logic [RANK_W-1:0] req_rank,
  output logic              req_is_read,
  output logic              cfg_err
);

  logic [PKT_W-1:0]  pkt_left;
  logic [BANK_W-1:0] bank_ctr, bank_q;
  logic [RANK_W-1:0] rank_ctr, rank_q;
  logic              half, type_q;

  wire mode_split = (cfg_rd_pct == 7'd50);
  wire mode_rd    = (cfg_rd_pct == 7'd100);
  wire mode_wr    = (cfg_rd_pct == 7'd0);

  assign cfg_err   = !(mode_split || mode_rd || mode_wr);
  assign req_valid = !cfg_err;
  assign req_first = (pkt_left == '0);

  wire type_new = mode_split ? ((bank_ctr == '0) ? !type_q : type_q) : mode_rd;

  assign req_bank    = req_first ? bank_ctr : bank_q;
  assign req_rank    = req_first ? rank_ctr : rank_q;
  assign req_is_read = req_first ? type_new : type_q;

  wire issue     = req_valid && req_ready;
  wire bank_last = ({1'b0, bank_ctr} + 1'b1) >= cfg_banks;
  wire rank_last = ({1'b0, rank_ctr} + 1'b1) >= cfg_ranks;
  wire rank_step = bank_last && (!mode_split || half);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_left <= '0;
      bank_ctr <= '0;
      rank_ctr <= '0;
      bank_q   <= '0;
      rank_q   <= '0;
      half     <= 1'b0;
      type_q   <= 1'b0;
    end else if (issue) begin
      if (req_first) begin
        pkt_left <= (cfg_pkts == '0) ? '0 : cfg_pkts - 1'b1;
        type_q   <= type_new;
        bank_q   <= bank_ctr;
        rank_q   <= rank_ctr;
        bank_ctr <= bank_last ? '0 : bank_ctr + 1'b1;
        if (bank_last)
          half <= mode_split ? !half : 1'b0;
        if (rank_step)
          rank_ctr <= rank_last ? '0 : rank_ctr + 1'b1;
      end else begin
        pkt_left <= pkt_left - 1'b1;
      end
    end
  end

  assert_freeze_on_err_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> ($stable(pkt_left) && $stable(bank_ctr) && $stable(rank_ctr) && $stable(type_q)));

  assert_single_pkt_series_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && req_first && cfg_pkts <= 1) |=> req_first);

  assert_series_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> (!req_first |-> ($stable(req_bank) && $stable(req_rank) && $stable(req_is_read))));

  assert_write_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_first && mode_wr) |-> !req_is_read);

  assert_read_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_first && mode_rd) |-> req_is_read);

endmodule

// File: tb/bank_rank_rotator_tb_top.sv
`timescale 1ns/1ps
module bank_rank_rotator_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] cfg_banks;
  logic [2:0] cfg_ranks;
  logic [6:0] cfg_rd_pct;
  logic [7:0] cfg_pkts;
  logic       req_ready;
  logic       req_valid, req_first, req_is_read, cfg_err;
  logic [2:0] req_bank;
  logic [1:0] req_rank;

  int applied = 0;
  int miscmp  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  bank_rank_rotator dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_banks(cfg_banks), .cfg_ranks(cfg_ranks),
    .cfg_rd_pct(cfg_rd_pct), .cfg_pkts(cfg_pkts), .req_ready(req_ready),
    .req_valid(req_valid), .req_first(req_first), .req_bank(req_bank),
    .req_rank(req_rank), .req_is_read(req_is_read), .cfg_err(cfg_err)
  );

  // {count, banks, ranks, pct, pkts}
  localparam logic [39:0] VECS [9] = '{
    {8'd40, 8'd4, 8'd2, 8'd100, 8'd3},
    {8'd30, 8'd4, 8'd2, 8'd0,   8'd2},
    {8'd40, 8'd4, 8'd2, 8'd50,  8'd1},
    {8'd60, 8'd3, 8'd3, 8'd50,  8'd2},
    {8'd40, 8'd8, 8'd4, 8'd100, 8'd1},
    {8'd10, 8'd1, 8'd1, 8'd50,  8'd2},
    {8'd20, 8'd2, 8'd4, 8'd0,   8'd1},
    {8'd40, 8'd5, 8'd1, 8'd50,  8'd3},
    {8'd8,  8'd4, 8'd1, 8'd100, 8'd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    applied++;
    if (!ok) begin
      miscmp++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_ready = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_vec(input int b, input int r, input int p, input int n, input int cnt);
    int pk, spr;
    cfg_banks = 4'(b); cfg_ranks = 3'(r); cfg_rd_pct = 7'(p); cfg_pkts = 8'(n);
    do_reset();
    pk  = (n == 0) ? 1 : n;
    spr = (p == 50) ? 2 * b : b;
    req_ready = 1'b1;
    for (int k = 0; k < cnt; k++) begin
      int s, eb, er, ed;
      bit ef;
      s  = (k / pk) % (r * spr);
      ef = (k % pk) == 0;
      eb = s % b;
      er = (s / spr) % r;
      ed = (p == 100) ? 1 : (p == 0) ? 0 : (((s / b) % 2) == 0);
      #1;
      chk(req_valid == 1'b1, "R2 valid", int'(req_valid), 1);
      chk(req_first == ef, "R2 first", int'(req_first), int'(ef));
      chk(int'(req_bank) == eb, "R3 bank", int'(req_bank), eb);
      chk(int'(req_rank) == er, "R4/R5 rank", int'(req_rank), er);
      chk(int'(req_is_read) == ed, (p == 50) ? "R6 type" : "R7 type", int'(req_is_read), ed);
      @(negedge clk);
    end
    req_ready = 1'b0;
  endtask

  initial begin
    cfg_banks = 4'd4; cfg_ranks = 3'd2; cfg_rd_pct = 7'd100; cfg_pkts = 8'd3;
    do_reset();
    #1;
    chk(req_valid && req_first, "R8 first after reset", int'(req_first), 1);
    chk(req_bank == 3'd0 && req_rank == 2'd0, "R8 bank/rank", int'({req_rank, req_bank}), 0);
    chk(cfg_err == 1'b0, "R1 legal pct", int'(cfg_err), 0);

    for (int i = 0; i < 9; i++)
      run_vec(int'(VECS[i][31:24]), int'(VECS[i][23:16]), int'(VECS[i][15:8]),
              int'(VECS[i][7:0]), int'(VECS[i][39:32]));

    cfg_banks = 4'd4; cfg_ranks = 3'd2; cfg_rd_pct = 7'd100; cfg_pkts = 8'd1;
    do_reset();
    req_ready = 1'b1;
    repeat (2) @(negedge clk);
    cfg_rd_pct = 7'd30;
    #1;
    chk(cfg_err == 1'b1, "R1 err flag", int'(cfg_err), 1);
    chk(req_valid == 1'b0, "R1 valid gated", int'(req_valid), 0);
    repeat (4) @(negedge clk);
    cfg_rd_pct = 7'd100;
    #1;
    chk(req_bank == 3'd2, "R1 frozen during err", int'(req_bank), 2);
    req_ready = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(req_bank == 3'd2 && req_first, "R2 stall no advance", int'(req_bank), 2);
    req_ready = 1'b1;
    @(negedge clk);
    #1;
    chk(req_bank == 3'd3, "R2 advance after stall", int'(req_bank), 3);
    req_ready = 1'b0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscmp++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
      $finish;
    end
  end

endmodule